// File: doc/BRIEF.md
# SIMT Warp Issue Unit with Divergence Stack

This block sits in one multiprocessor and tracks a set of resident warps, each with 32 lanes. In every clock it chooses at most one eligible warp and sends out an issue record: the warp index, that warp's PC and the lane mask under which all lanes execute in lock-step. Fetch, decode and execution stay outside the block. The execution side returns branch information for the instruction issued in the same cycle: the lanes that take the branch, the branch target and the reconvergence PC.

When the active lanes disagree on a branch, the warp keeps a small per-warp stack so that the two paths run one after the other. The taken side runs first under the taken lanes. When it reaches the reconvergence PC, the fall-through side runs under the remaining lanes. When that side also arrives there, the original mask returns. The total cost is therefore the sum of both path lengths. A separate launch port loads a warp's starting PC and mask.

Top module: `simt_issue`

## Requirements
- R1: While reset is held and after it is released, no issue is made until a warp becomes eligible, and `stack_err` is 0.
- R2: A warp is eligible only when its `warp_valid` bit is 1, its `warp_stall` bit is 0 and its current lane mask is non-zero. Bit i of every lane mask stands for lane i.
- R3: Among eligible warps, the pick is round-robin, starting at the index one above the last warp issued and wrapping at NW. After reset the search starts at warp 0.
- R4: The issue record carries the warp's current PC and mask. A non-branch, or a branch that no active lane takes, advances the PC by one. A branch that every active lane takes moves the PC to the target. In both cases the mask is kept and nothing is pushed.
- R5: A branch whose active lanes split pushes an entry and continues at the target under only the taken active lanes.
- R6: When the next PC of a warp equals the reconvergence PC of its top entry, and the fall-through side has not run yet, the warp switches to the branch PC + 1 under the not-taken lanes.
- R7: When the fall-through side then reaches the same reconvergence PC, the entry is popped and the full pre-branch mask is restored at that PC.
- R8: A split branch on a warp whose stack already holds DEPTH entries sets `stack_err`. The flag stays 1 until reset. The warp continues on the taken side under the taken lanes, and nothing is pushed.
- R9: A launch sets the chosen warp's PC and mask and empties its stack. A launch wins over an issue update to the same warp in the same cycle.
- R10: A split branch whose target equals its reconvergence PC goes straight to the fall-through side under the not-taken lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NW | Warp resident flags |
| warp_stall | input | NW | Warp stalled flags |
| launch_en | input | 1 | Load a warp's PC and mask |
| launch_warp | input | log2(NW) | Warp to load |
| launch_pc | input | PCW | Starting PC |
| launch_mask | input | LANES | Starting lane mask |
| br_en | input | 1 | Issued instruction is a branch |
| br_taken | input | LANES | Lanes whose branch condition holds |
| br_target | input | PCW | Branch target PC |
| br_reconv | input | PCW | Reconvergence PC of the branch |
| iss_valid | output | 1 | An issue is made this cycle |
| iss_warp | output | log2(NW) | Issued warp index |
| iss_pc | output | PCW | Issued PC |
| iss_mask | output | LANES | Issued lane mask |
| stack_err | output | 1 | Sticky divergence-stack overflow flag |

## Verification
The assertions assume that the branch inputs describe the instruction issued in that same cycle. They also assume that `br_en` is 0 whenever nothing is issued, and that a launch is not used to rewrite a warp while it is mid-assertion window. The bench holds the branch inputs at zero in cycles where nothing is issued. It lowers a warp's valid bit during the cycle that warp is launched. Its branch targets are chosen so that a fall-through PC never coincides with a reconvergence PC.

// File: rtl/simt_issue.sv
module simt_issue #(
  parameter int NW    = 64,
  parameter int LANES = 32,
  parameter int PCW   = 16,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          warp_valid,
  input  logic [NW-1:0]          warp_stall,
  input  logic                   launch_en,
  input  logic [$clog2(NW)-1:0]  launch_warp,
  input  logic [PCW-1:0]         launch_pc,
  input  logic [LANES-1:0]       launch_mask,
  input  logic                   br_en,
  input  logic [LANES-1:0]       br_taken,
  input  logic [PCW-1:0]         br_target,
  input  logic [PCW-1:0]         br_reconv,
  output logic                   iss_valid,
  output logic [$clog2(NW)-1:0]  iss_warp,
  output logic [PCW-1:0]         iss_pc,
  output logic [LANES-1:0]       iss_mask,
  output logic                   stack_err
);
  localparam int WW = $clog2(NW);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PCW-1:0]   pc_q   [NW];
  logic [LANES-1:0] mask_q [NW];
  logic [SW-1:0]    sp_q   [NW];
  logic [WW-1:0]    last_q;

  logic [PCW-1:0]   st_rpc [NW][DEPTH];
  logic [PCW-1:0]   st_npc [NW][DEPTH];
  logic [LANES-1:0] st_nm  [NW][DEPTH];
  logic [LANES-1:0] st_fm  [NW][DEPTH];
  logic             st_ph  [NW][DEPTH];

  logic [NW-1:0] elig;
  for (genvar i = 0; i < NW; i++) begin : g_elig
    assign elig[i] = warp_valid[i] & ~warp_stall[i] & (|mask_q[i]);
  end

  logic [WW-1:0] pick, cand;
  logic          pick_ok;
  always_comb begin
    pick_ok = 1'b0;
    pick    = last_q;
    cand    = last_q;
    for (int k = 1; k <= NW; k++) begin
      cand = WW'((int'(last_q) + k) % NW);
      if (!pick_ok && elig[cand]) begin
        pick_ok = 1'b1;
        pick    = cand;
      end
    end
  end

  assign iss_valid = pick_ok;
  assign iss_warp  = pick;
  assign iss_pc    = pc_q[pick];
  assign iss_mask  = mask_q[pick];

  logic [SW-1:0]    cur_sp;
  logic [DW-1:0]    top_i, push_i;
  logic [LANES-1:0] tk, nt, n_m, t_nm, t_fm;
  logic [PCW-1:0]   n_pc, t_rpc, t_npc;
  logic             do_push, ovf, has_top, t_ph, sw_path, do_pop;

  assign cur_sp = sp_q[pick];
  assign top_i  = DW'(cur_sp - SW'(1));
  assign push_i = DW'(cur_sp);
  assign tk     = br_taken & iss_mask;
  assign nt     = iss_mask & ~br_taken;

  always_comb begin
    n_pc    = iss_pc + PCW'(1);
    n_m     = iss_mask;
    do_push = 1'b0;
    ovf     = 1'b0;
    if (br_en && tk != '0) begin
      n_pc = br_target;
      if (nt != '0) begin
        n_m = tk;
        if (int'(cur_sp) == DEPTH) ovf = 1'b1;
        else                       do_push = 1'b1;
      end
    end
    has_top = do_push || (cur_sp != '0);
    t_rpc = do_push ? br_reconv           : st_rpc[pick][top_i];
    t_npc = do_push ? iss_pc + PCW'(1)    : st_npc[pick][top_i];
    t_nm  = do_push ? nt                  : st_nm[pick][top_i];
    t_fm  = do_push ? iss_mask            : st_fm[pick][top_i];
    t_ph  = do_push ? 1'b0                : st_ph[pick][top_i];
    sw_path = 1'b0;
    do_pop  = 1'b0;
    if (has_top && n_pc == t_rpc) begin
      if (!t_ph) begin
        sw_path = 1'b1;
        n_pc    = t_npc;
        n_m     = t_nm;
      end else begin
        do_pop = 1'b1;
        n_m    = t_fm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= WW'(NW - 1);
      stack_err <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        pc_q[i]   <= '0;
        mask_q[i] <= '0;
        sp_q[i]   <= '0;
      end
    end else begin
      if (iss_valid) begin
        last_q       <= pick;
        pc_q[pick]   <= n_pc;
        mask_q[pick] <= n_m;
        if (do_push)     sp_q[pick] <= cur_sp + SW'(1);
        else if (do_pop) sp_q[pick] <= cur_sp - SW'(1);
        if (ovf) stack_err <= 1'b1;
      end
      if (launch_en) begin
        pc_q[launch_warp]   <= launch_pc;
        mask_q[launch_warp] <= launch_mask;
        sp_q[launch_warp]   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (iss_valid && do_push) begin
      st_rpc[pick][push_i] <= br_reconv;
      st_npc[pick][push_i] <= iss_pc + PCW'(1);
      st_nm[pick][push_i]  <= nt;
      st_fm[pick][push_i]  <= iss_mask;
      st_ph[pick][push_i]  <= sw_path;
    end else if (iss_valid && sw_path) begin
      st_ph[pick][top_i] <= 1'b1;
    end
  end

  a_r2_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (warp_valid[iss_warp] && !warp_stall[iss_warp] && iss_mask != '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  a_r4_uniform_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && br_en && !launch_en &&
     ((br_taken & iss_mask) == iss_mask || (br_taken & iss_mask) == '0))
    |=> sp_q[$past(iss_warp)] <= $past(sp_q[iss_warp]));

  a_r5_split_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && br_en && !launch_en && (br_taken & iss_mask) != '0 &&
     (iss_mask & ~br_taken) != '0)
    |=> ((mask_q[$past(iss_warp)] & ~$past(iss_mask)) == '0 &&
         mask_q[$past(iss_warp)] != $past(iss_mask)));

  a_r1_no_issue_in_reset: assert property (@(posedge clk)
    !rst_n |=> !stack_err);
endmodule

// File: tb/test_simt_issue.sv
module test_simt_issue;
  localparam int NW = 64, LANES = 32, PCW = 16, DEPTH = 2;
  localparam int WW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n;
  logic [NW-1:0] warp_valid, warp_stall;
  logic launch_en;
  logic [WW-1:0] launch_warp;
  logic [PCW-1:0] launch_pc;
  logic [LANES-1:0] launch_mask;
  logic br_en;
  logic [LANES-1:0] br_taken;
  logic [PCW-1:0] br_target, br_reconv;
  logic iss_valid;
  logic [WW-1:0] iss_warp;
  logic [PCW-1:0] iss_pc;
  logic [LANES-1:0] iss_mask;
  logic stack_err;

  always #2 clk = ~clk;

  simt_issue #(.NW(NW), .LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) i_simt_issue (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_stall(warp_stall),
    .launch_en(launch_en), .launch_warp(launch_warp), .launch_pc(launch_pc),
    .launch_mask(launch_mask), .br_en(br_en), .br_taken(br_taken),
    .br_target(br_target), .br_reconv(br_reconv), .iss_valid(iss_valid),
    .iss_warp(iss_warp), .iss_pc(iss_pc), .iss_mask(iss_mask), .stack_err(stack_err));

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  localparam int NV = 11;
  localparam logic        V_BR [NV] = '{0, 1, 0, 1, 0, 0, 1, 1, 0, 1, 0};
  localparam logic [31:0] V_TK [NV] = '{0, 32'h0000FFFF, 0, 32'h0000FFFF, 0, 0,
                                        32'hFFFFFFFF, 32'h00000001, 0, 32'hFFFFFFFF, 0};
  localparam logic [15:0] V_TG [NV] = '{0, 20, 0, 29, 0, 0, 30, 40, 0, 40, 0};
  localparam logic [15:0] V_RC [NV] = '{0, 30, 0, 99, 0, 0, 50, 40, 0, 0, 0};
  localparam logic [15:0] E_PC [NV] = '{10, 11, 20, 21, 29, 12, 13, 30, 31, 32, 40};
  localparam logic [31:0] E_M  [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h0000FFFF,
                                        32'h0000FFFF, 32'hFFFF0000, 32'hFFFF0000, 32'hFFFFFFFF,
                                        32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFF};
  localparam string V_REQ [NV] = '{"R9", "R4", "R5", "R4", "R4", "R6", "R6", "R7",
                                   "R10", "R10", "R7"};

  task automatic launch(input int w, input logic [15:0] pc, input logic [31:0] m);
    warp_valid = '0;
    launch_en = 1'b1; launch_warp = WW'(w); launch_pc = pc; launch_mask = m;
    @(posedge clk); @(negedge clk);
    launch_en = 1'b0;
  endtask

  task automatic step(input logic be, input logic [31:0] tkn, input logic [15:0] tg,
                      input logic [15:0] rc, input int ew, input logic [15:0] epc,
                      input logic [31:0] em, input string req);
    br_en = be; br_taken = tkn; br_target = tg; br_reconv = rc;
    #1;
    chk(iss_valid == 1'b1, req, {31'd0, iss_valid}, 32'd1);
    chk(int'(iss_warp) == ew, req, {26'd0, iss_warp}, ew);
    chk(iss_pc == epc, req, {16'd0, iss_pc}, {16'd0, epc});
    chk(iss_mask == em, req, iss_mask, em);
    @(posedge clk); @(negedge clk);
    br_en = 1'b0; br_taken = '0; br_target = '0; br_reconv = '0;
  endtask

  initial begin
    rst_n = 1'b0; warp_valid = '0; warp_stall = '0; launch_en = 1'b0;
    launch_warp = '0; launch_pc = '0; launch_mask = '0;
    br_en = 1'b0; br_taken = '0; br_target = '0; br_reconv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(iss_valid == 1'b0, "R1", {31'd0, iss_valid}, 0);
    chk(stack_err == 1'b0, "R1", {31'd0, stack_err}, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    warp_valid = '1;
    #1;
    chk(iss_valid == 1'b0, "R2 zero mask", {31'd0, iss_valid}, 0);
    chk(stack_err == 1'b0, "R1", {31'd0, stack_err}, 0);

    launch(3, 16'd10, 32'hFFFFFFFF);
    warp_valid = 64'd1 << 3;
    for (int v = 0; v < NV; v++)
      step(V_BR[v], V_TK[v], V_TG[v], V_RC[v], 3, E_PC[v], E_M[v], V_REQ[v]);

    launch(7, 16'd100, 32'hFFFFFFFF);
    warp_valid = 64'd1 << 7;
    step(1, 32'h0000FFFF, 200, 300, 7, 100, 32'hFFFFFFFF, "R5");
    step(1, 32'h000000FF, 210, 250, 7, 200, 32'h0000FFFF, "R5");
    chk(stack_err == 1'b0, "R8 not yet full", {31'd0, stack_err}, 0);
    step(1, 32'h0000000F, 220, 240, 7, 210, 32'h000000FF, "R8");
    chk(stack_err == 1'b1, "R8 overflow", {31'd0, stack_err}, 1);
    step(0, 0, 0, 0, 7, 220, 32'h0000000F, "R8 taken side kept");
    chk(stack_err == 1'b1, "R8 sticky", {31'd0, stack_err}, 1);

    launch(7, 16'd500, 32'hFFFFFFFF);
    warp_valid = 64'd1 << 7;
    step(1, 32'h00000001, 600, 601, 7, 500, 32'hFFFFFFFF, "R9");
    step(0, 0, 0, 0, 7, 600, 32'h00000001, "R9");
    step(0, 0, 0, 0, 7, 501, 32'hFFFFFFFE, "R9 stack cleared");

    launch(0, 16'd1000, 32'h1);
    launch(1, 16'd2000, 32'h2);
    launch(2, 16'd3000, 32'h4);
    warp_valid = 64'h7;
    step(0, 0, 0, 0, 0, 1000, 32'h1, "R3");
    step(0, 0, 0, 0, 1, 2000, 32'h2, "R3");
    step(0, 0, 0, 0, 2, 3000, 32'h4, "R3");
    step(0, 0, 0, 0, 0, 1001, 32'h1, "R3 wrap");
    warp_stall = 64'h2;
    step(0, 0, 0, 0, 2, 3001, 32'h4, "R2 stalled skipped");
    step(0, 0, 0, 0, 0, 1002, 32'h1, "R3");
    warp_stall = 64'h7;
    #1;
    chk(iss_valid == 1'b0, "R2 all stalled", {31'd0, iss_valid}, 0);
    warp_stall = '0;
    finish_run();
  end
endmodule